// File: doc/BRIEF.md
# Stepped Charge-Injection Calibration Sequencer

This block runs an unattended calibration scan of a multi-channel charge front end. The scan starts from a single start pulse. It first writes a trigger threshold code to one output of a two-output DAC. It then walks the input channels in order. For each channel it raises the calibration output of the same DAC in equal increments. For every amplitude it closes an analog switch to make a voltage step, which a small series capacitor turns into a test charge, and it starts one conversion of the shaped pulse.

Each amplitude is repeated a configurable number of times. Every conversion result goes out on a valid/ready stream as a record tagged with its channel and step index. The serial DAC transfer is reduced to a one-cycle load strobe answered by a one-cycle done strobe. The conversion is reduced to a start strobe answered by a valid strobe with the result.

The step size, number of steps, repeat count, settling delay and threshold word are sampled when the scan starts. An abort input ends a scan early and leaves the front end quiet.

Top module: `cal_scan_seq`

## Requirements
- R1: A start pulse in idle loads the threshold word on DAC output 1 (`dac_sel`=1) as the first load of the scan, and only once per scan. A start pulse while `busy` is high has no effect on the scan in progress.
- R2: Calibration loads use DAC output 0 (`dac_sel`=0). For every channel, the words are k times the step size for k = 1 up to the number of steps, in rising order.
- R3: `pulse_sw` is low (open) in every cycle in which `dac_load` is high. The switch closes, together with a one-cycle `adc_start`, exactly `cfg_settle`+1 clock edges after the edge that takes the calibration `dac_done`, or after the edge that accepts a record when the same amplitude is repeated.
- R4: Each amplitude yields `cfg_repeats` records. A repeat count or step count of 0 is treated as 1.
- R5: Channels are scanned from 0 to NUM_CH-1. `ch_sel` holds the channel under calibration while its conversions run.
- R6: A record carries the channel index, the zero-based step index and the conversion result. `rec_last` is set only on the final record of a complete scan.
- R7: Once `rec_valid` is high, it and the record fields hold unchanged until `rec_ready` is seen, unless abort is asserted.
- R8: After the final record is accepted, output 0 of the DAC is loaded with zero. `busy` then falls on the edge that takes the matching `dac_done`.
- R9: Abort while busy opens the switch and drops any pending record on the next edge. Output 0 is then loaded with zero, after any load already in flight has completed. The block returns to idle and emits no further records.
- R10: After reset, `busy`, `pulse_sw`, `dac_load`, `adc_start` and `rec_valid` are low.
- R11: The switch opens, and the record becomes valid, on the edge that takes `adc_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a scan (taken in idle only) |
| abort | input | 1 | Cancel the scan in progress |
| cfg_step_size | input | DAC_W | Amplitude increment per step |
| cfg_num_steps | input | STEP_W | Number of amplitude steps per channel |
| cfg_repeats | input | REP_W | Conversions per amplitude |
| cfg_settle | input | SETTLE_W | Settling cycles before the switch closes |
| cfg_threshold | input | DAC_W | Trigger threshold word |
| dac_load | output | 1 | One-cycle DAC load strobe |
| dac_sel | output | 1 | DAC output select, 0 calibration, 1 threshold |
| dac_word | output | DAC_W | DAC code for the load |
| dac_done | input | 1 | One-cycle load completion |
| pulse_sw | output | 1 | Analog pulse switch, 1 closed |
| ch_sel | output | CH_W | Channel under calibration |
| adc_start | output | 1 | One-cycle conversion start |
| adc_valid | input | 1 | One-cycle conversion result valid |
| adc_data | input | ADC_W | Conversion result |
| rec_valid | output | 1 | Record valid |
| rec_ready | input | 1 | Record accepted by downstream |
| rec_channel | output | CH_W | Record channel index |
| rec_step | output | STEP_W | Record step index |
| rec_data | output | ADC_W | Record conversion result |
| rec_last | output | 1 | Final record of the scan |
| busy | output | 1 | Scan in progress |

## Verification
The assertions take it as given that `dac_done` arrives as a single-cycle pulse only after a load strobe. They also take it as given that `adc_valid` comes only after `adc_start`, and that the configuration inputs stay put while `busy` is high. The bench meets these conditions with behavioural DAC and ADC responders that answer each strobe once, after a fixed latency. Its stimulus tasks change configuration only between scans. Abort is driven at two chosen points, during a conversion and during the threshold load, so that both the immediate and the deferred zero-load paths are exercised.

// File: rtl/cal_scan_pkg.sv
package cal_scan_pkg;

  // Sequencer phases
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_THR_WT,   // threshold load in flight
    ST_CAL_WT,   // calibration level load in flight
    ST_SETTLE,   // switch open, level settling
    ST_CONV,     // switch closed, waiting for conversion
    ST_EMIT,     // record offered downstream
    ST_ZERO_WT   // parking the calibration output at zero
  } scan_state_t;

endpackage

// File: rtl/cal_scan_ctr.sv
module cal_scan_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/cal_scan_level.sv
module cal_scan_level #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_first,
  input  logic         advance,
  input  logic [W-1:0] step,
  output logic [W-1:0] level,
  output logic [W-1:0] level_next
);

  // Running amplitude: replaces a multiplier by one adder
  assign level_next = level + step;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
    end else if (load_first) begin
      level <= step;
    end else if (advance) begin
      level <= level_next;
    end
  end

endmodule

// File: rtl/cal_scan_seq.sv
module cal_scan_seq
  import cal_scan_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int DAC_W    = 12,
  parameter int ADC_W    = 14,
  parameter int STEP_W   = 8,
  parameter int REP_W    = 11,
  parameter int SETTLE_W = 8,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                abort,
  input  logic [DAC_W-1:0]    cfg_step_size,
  input  logic [STEP_W-1:0]   cfg_num_steps,
  input  logic [REP_W-1:0]    cfg_repeats,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic [DAC_W-1:0]    cfg_threshold,
  output logic                dac_load,
  output logic                dac_sel,
  output logic [DAC_W-1:0]    dac_word,
  input  logic                dac_done,
  output logic                pulse_sw,
  output logic [CH_W-1:0]     ch_sel,
  output logic                adc_start,
  input  logic                adc_valid,
  input  logic [ADC_W-1:0]    adc_data,
  output logic                rec_valid,
  input  logic                rec_ready,
  output logic [CH_W-1:0]     rec_channel,
  output logic [STEP_W-1:0]   rec_step,
  output logic [ADC_W-1:0]    rec_data,
  output logic                rec_last,
  output logic                busy
);

  localparam int CH_CW = CH_W + 1;
  localparam logic [CH_CW-1:0] CH_LAST = CH_CW'(NUM_CH - 1);

  scan_state_t st, nxt;

  // Configuration captured at start
  logic [DAC_W-1:0]    step_cap;
  logic [STEP_W-1:0]   steps_lim;
  logic [REP_W-1:0]    reps_lim;
  logic [SETTLE_W-1:0] settle_cap;
  logic                abort_pend;

  // Loop counters
  logic [CH_CW-1:0]    ch_cnt;
  logic [STEP_W-1:0]   stp_cnt;
  logic [REP_W-1:0]    rep_cnt;
  logic [SETTLE_W-1:0] set_cnt;
  logic [DAC_W-1:0]    level, level_next;

  logic ch_clr, ch_inc, stp_clr, stp_inc, rep_clr, rep_inc, set_clr, set_inc;
  logic lvl_first, lvl_adv;
  logic ld_req, ld_sel;
  logic [DAC_W-1:0] ld_word;
  logic sw_close, sw_open, rec_set, rec_clr, pend_set, cfg_cap;
  logic ch_last, stp_last, rep_last, set_last;

  assign ch_last  = (ch_cnt == CH_LAST);
  assign stp_last = (stp_cnt == steps_lim - 1'b1);
  assign rep_last = (rep_cnt == reps_lim - 1'b1);
  assign set_last = (set_cnt == settle_cap);

  cal_scan_ctr #(.W(CH_CW)) u_ch_ctr (
    .clk(clk), .rst(rst), .clr(ch_clr), .inc(ch_inc), .count(ch_cnt)
  );

  cal_scan_ctr #(.W(STEP_W)) u_step_ctr (
    .clk(clk), .rst(rst), .clr(stp_clr), .inc(stp_inc), .count(stp_cnt)
  );

  cal_scan_ctr #(.W(REP_W)) u_rep_ctr (
    .clk(clk), .rst(rst), .clr(rep_clr), .inc(rep_inc), .count(rep_cnt)
  );

  cal_scan_ctr #(.W(SETTLE_W)) u_settle_ctr (
    .clk(clk), .rst(rst), .clr(set_clr), .inc(set_inc), .count(set_cnt)
  );

  cal_scan_level #(.W(DAC_W)) u_level (
    .clk(clk), .rst(rst), .load_first(lvl_first), .advance(lvl_adv),
    .step(step_cap), .level(level), .level_next(level_next)
  );

  // Next-state and strobe decode
  always_comb begin
    nxt       = st;
    ld_req    = 1'b0;
    ld_sel    = 1'b0;
    ld_word   = '0;
    ch_clr    = 1'b0;
    ch_inc    = 1'b0;
    stp_clr   = 1'b0;
    stp_inc   = 1'b0;
    rep_clr   = 1'b0;
    rep_inc   = 1'b0;
    set_clr   = 1'b0;
    set_inc   = 1'b0;
    lvl_first = 1'b0;
    lvl_adv   = 1'b0;
    sw_close  = 1'b0;
    sw_open   = 1'b0;
    rec_set   = 1'b0;
    rec_clr   = 1'b0;
    pend_set  = 1'b0;
    cfg_cap   = 1'b0;
    if (abort && st != ST_IDLE) begin
      sw_open = 1'b1;
      rec_clr = 1'b1;
      case (st)
        ST_THR_WT, ST_CAL_WT: begin
          if (dac_done) begin
            ld_req = 1'b1;
            nxt    = ST_ZERO_WT;
          end else begin
            pend_set = 1'b1;
          end
        end
        ST_ZERO_WT: begin
          if (dac_done) nxt = ST_IDLE;
        end
        default: begin
          ld_req = 1'b1;
          nxt    = ST_ZERO_WT;
        end
      endcase
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            cfg_cap = 1'b1;
            ld_req  = 1'b1;
            ld_sel  = 1'b1;
            ld_word = cfg_threshold;
            ch_clr  = 1'b1;
            stp_clr = 1'b1;
            rep_clr = 1'b1;
            nxt     = ST_THR_WT;
          end
        end
        ST_THR_WT: begin
          if (dac_done) begin
            ld_req = 1'b1;
            if (abort_pend) begin
              nxt = ST_ZERO_WT;
            end else begin
              ld_word   = step_cap;
              lvl_first = 1'b1;
              nxt       = ST_CAL_WT;
            end
          end
        end
        ST_CAL_WT: begin
          if (dac_done) begin
            if (abort_pend) begin
              ld_req = 1'b1;
              nxt    = ST_ZERO_WT;
            end else begin
              set_clr = 1'b1;
              nxt     = ST_SETTLE;
            end
          end
        end
        ST_SETTLE: begin
          if (set_last) begin
            sw_close = 1'b1;
            nxt      = ST_CONV;
          end else begin
            set_inc = 1'b1;
          end
        end
        ST_CONV: begin
          if (adc_valid) begin
            sw_open = 1'b1;
            rec_set = 1'b1;
            nxt     = ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (rec_ready) begin
            rec_clr = 1'b1;
            if (!rep_last) begin
              rep_inc = 1'b1;
              set_clr = 1'b1;
              nxt     = ST_SETTLE;
            end else if (!stp_last) begin
              rep_clr = 1'b1;
              stp_inc = 1'b1;
              lvl_adv = 1'b1;
              ld_req  = 1'b1;
              ld_word = level_next;
              nxt     = ST_CAL_WT;
            end else if (!ch_last) begin
              rep_clr   = 1'b1;
              stp_clr   = 1'b1;
              ch_inc    = 1'b1;
              lvl_first = 1'b1;
              ld_req    = 1'b1;
              ld_word   = step_cap;
              nxt       = ST_CAL_WT;
            end else begin
              ld_req = 1'b1;
              nxt    = ST_ZERO_WT;
            end
          end
        end
        ST_ZERO_WT: begin
          if (dac_done) nxt = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  // Registered state and outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      busy        <= 1'b0;
      abort_pend  <= 1'b0;
      step_cap    <= '0;
      steps_lim   <= '0;
      reps_lim    <= '0;
      settle_cap  <= '0;
      dac_load    <= 1'b0;
      dac_sel     <= 1'b0;
      dac_word    <= '0;
      pulse_sw    <= 1'b0;
      adc_start   <= 1'b0;
      rec_valid   <= 1'b0;
      rec_channel <= '0;
      rec_step    <= '0;
      rec_data    <= '0;
      rec_last    <= 1'b0;
    end else begin
      st        <= nxt;
      busy      <= (nxt != ST_IDLE);
      dac_load  <= ld_req;
      adc_start <= sw_close;
      if (st == ST_IDLE) begin
        abort_pend <= 1'b0;
      end else if (pend_set) begin
        abort_pend <= 1'b1;
      end
      if (cfg_cap) begin
        step_cap   <= cfg_step_size;
        steps_lim  <= (cfg_num_steps == '0) ? STEP_W'(1) : cfg_num_steps;
        reps_lim   <= (cfg_repeats == '0) ? REP_W'(1) : cfg_repeats;
        settle_cap <= cfg_settle;
      end
      if (ld_req) begin
        dac_sel  <= ld_sel;
        dac_word <= ld_word;
      end
      if (sw_open) begin
        pulse_sw <= 1'b0;
      end else if (sw_close) begin
        pulse_sw <= 1'b1;
      end
      if (rec_clr) begin
        rec_valid <= 1'b0;
      end else if (rec_set) begin
        rec_valid   <= 1'b1;
        rec_channel <= ch_cnt[CH_W-1:0];
        rec_step    <= stp_cnt;
        rec_data    <= adc_data;
        rec_last    <= ch_last && stp_last && rep_last;
      end
    end
  end

  assign ch_sel = ch_cnt[CH_W-1:0];

endmodule

// File: rtl/cal_scan_chk.sv
module cal_scan_chk #(
  parameter int CH_W   = 2,
  parameter int STEP_W = 8,
  parameter int ADC_W  = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              abort,
  input logic              busy,
  input logic              dac_load,
  input logic              pulse_sw,
  input logic              adc_start,
  input logic              rec_valid,
  input logic              rec_ready,
  input logic [CH_W-1:0]   rec_channel,
  input logic [STEP_W-1:0] rec_step,
  input logic [ADC_W-1:0]  rec_data,
  input logic              rec_last
);

  // R3
  sw_open_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    dac_load |-> !pulse_sw);

  // R3
  conv_with_sw_chk: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> pulse_sw);

  // R7
  rec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready && !abort) |=>
      (rec_valid && $stable(rec_data) && $stable(rec_channel) &&
       $stable(rec_step) && $stable(rec_last)));

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (abort && busy) |=> (!pulse_sw && !rec_valid));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!pulse_sw && !rec_valid && !adc_start));

endmodule

bind cal_scan_seq cal_scan_chk #(
  .CH_W(CH_W), .STEP_W(STEP_W), .ADC_W(ADC_W)
) u_chk (
  .clk(clk), .rst(rst), .abort(abort), .busy(busy), .dac_load(dac_load),
  .pulse_sw(pulse_sw), .adc_start(adc_start), .rec_valid(rec_valid),
  .rec_ready(rec_ready), .rec_channel(rec_channel), .rec_step(rec_step),
  .rec_data(rec_data), .rec_last(rec_last)
);

// File: tb/cal_scan_seq_tb.sv
module cal_scan_seq_tb_top;

  localparam int NCH  = 4;
  localparam int DW   = 12;
  localparam int AW   = 14;
  localparam int SW   = 8;
  localparam int RW   = 11;
  localparam int TW   = 8;
  localparam int CHW  = 2;
  localparam int DLAT = 3;
  localparam int ALAT = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          start = 1'b0, abort = 1'b0;
  logic [DW-1:0] cfg_step_size = '0, cfg_threshold = '0;
  logic [SW-1:0] cfg_num_steps = '0;
  logic [RW-1:0] cfg_repeats = '0;
  logic [TW-1:0] cfg_settle = '0;
  logic          dac_load, dac_sel, dac_done = 1'b0;
  logic [DW-1:0] dac_word;
  logic          pulse_sw, adc_start, adc_valid = 1'b0;
  logic [CHW-1:0] ch_sel, rec_channel;
  logic [AW-1:0] adc_data = '0, rec_data;
  logic          rec_valid, rec_ready = 1'b1, rec_last, busy;
  logic [SW-1:0] rec_step;

  cal_scan_seq #(
    .NUM_CH(NCH), .DAC_W(DW), .ADC_W(AW), .STEP_W(SW), .REP_W(RW), .SETTLE_W(TW)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .cfg_step_size(cfg_step_size), .cfg_num_steps(cfg_num_steps),
    .cfg_repeats(cfg_repeats), .cfg_settle(cfg_settle),
    .cfg_threshold(cfg_threshold), .dac_load(dac_load), .dac_sel(dac_sel),
    .dac_word(dac_word), .dac_done(dac_done), .pulse_sw(pulse_sw),
    .ch_sel(ch_sel), .adc_start(adc_start), .adc_valid(adc_valid),
    .adc_data(adc_data), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_channel(rec_channel), .rec_step(rec_step), .rec_data(rec_data),
    .rec_last(rec_last), .busy(busy)
  );

  int errors = 0;
  int checks = 0;

  // Expected traffic
  int q_dsel[$], q_dword[$];
  int q_rch[$], q_rstep[$], q_rdata[$], q_rlast[$];

  // Responder and monitor state
  int cur_cal = 0, dcnt = 0, acnt = 0, adc_val = 0;
  int settle_cfg = 0, gap = 0;
  bit armed = 0, prev_sw = 0, hold_prev = 0, ab_next = 0, ab_seen = 0;
  int h_ch, h_step, h_data, h_last;
  int n_conv = 0, n_acc = 0;
  bit pend_sel = 0;
  int pend_word = 0;
  int rdy_mode = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Downstream ready pattern
  initial forever begin
    @(posedge clk);
    #1;
    rec_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
    cyc++;
  end

  // Reference model, responders and per-clock comparison
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      gap++;
      if (dac_load) chk(!pulse_sw, "R3 switch open during DAC load", pulse_sw, 0);
      if (pulse_sw && !prev_sw) begin
        chk(armed && gap == settle_cfg + 1, "R3 settle delay before close", gap, settle_cfg + 1);
        chk(adc_start, "R3 conversion start with switch close", adc_start, 1);
        armed = 0;
      end
      if (ab_next) begin
        chk(!pulse_sw && !rec_valid, "R9 abort opens switch and drops record",
            int'({pulse_sw, rec_valid}), 0);
        ab_next = 0;
      end
      if (hold_prev) begin
        chk(rec_valid && int'(rec_data) == h_data && int'(rec_channel) == h_ch &&
            int'(rec_step) == h_step && int'(rec_last) == h_last,
            "R7 record held under backpressure", int'(rec_data), h_data);
      end
      hold_prev = rec_valid && !rec_ready && !abort;
      h_ch = int'(rec_channel); h_step = int'(rec_step);
      h_data = int'(rec_data); h_last = int'(rec_last);
      if (adc_valid && !ab_seen) begin
        chk(!pulse_sw && rec_valid, "R11 switch opens and record valid on result",
            int'({pulse_sw, rec_valid}), 1);
      end
      if (dac_load) begin
        if (q_dsel.size() == 0) begin
          chk(0, "R1 unexpected DAC load", int'(dac_word), -1);
        end else begin
          int es, ew;
          es = q_dsel.pop_front();
          ew = q_dword.pop_front();
          chk(int'(dac_sel) == es, "R2 DAC output select", int'(dac_sel), es);
          chk(int'(dac_word) == ew, "R2 DAC word", int'(dac_word), ew);
        end
        pend_sel = dac_sel;
        pend_word = int'(dac_word);
        if (!dac_sel) cur_cal = int'(dac_word);
        dcnt = DLAT;
      end
      if (dac_done && !pend_sel && pend_word != 0) begin
        armed = 1;
        gap = 0;
      end
      if (rec_valid && rec_ready && !abort) begin
        if (q_rch.size() == 0) begin
          chk(0, "R6 unexpected record", int'(rec_data), -1);
        end else begin
          int ec, es2, ed, el;
          ec = q_rch.pop_front(); es2 = q_rstep.pop_front();
          ed = q_rdata.pop_front(); el = q_rlast.pop_front();
          chk(int'(rec_channel) == ec, "R5 record channel", int'(rec_channel), ec);
          chk(int'(rec_step) == es2, "R6 record step index", int'(rec_step), es2);
          chk(int'(rec_data) == ed, "R6 record result", int'(rec_data), ed);
          chk(int'(rec_last) == el, "R6 last flag", int'(rec_last), el);
        end
        armed = 1;
        gap = -1;
        n_acc++;
      end
      if (adc_start) begin
        n_conv++;
        adc_val = (cur_cal + int'(ch_sel) * 2048) % 16384;
        acnt = ALAT;
      end
      if (abort && busy) begin
        q_rch.delete(); q_rstep.delete(); q_rdata.delete(); q_rlast.delete();
        q_dsel.delete(); q_dword.delete();
        q_dsel.push_back(0); q_dword.push_back(0);
        ab_next = 1;
        ab_seen = 1;
      end
      prev_sw = pulse_sw;
    end
    dac_done = 1'b0;
    adc_valid = 1'b0;
    if (dcnt > 0) begin
      dcnt--;
      if (dcnt == 0) dac_done = 1'b1;
    end
    if (acnt > 0) begin
      acnt--;
      if (acnt == 0) begin
        adc_valid = 1'b1;
        adc_data = AW'(adc_val);
      end
    end
  end

  task automatic start_scan(input int ns, input int nr, input int st, input int sz, input int th);
    int es, er;
    es = (ns == 0) ? 1 : ns;
    er = (nr == 0) ? 1 : nr;
    q_dsel.push_back(1); q_dword.push_back(th);
    for (int c = 0; c < NCH; c++) begin
      for (int s = 0; s < es; s++) begin
        q_dsel.push_back(0); q_dword.push_back((s + 1) * sz);
        for (int r = 0; r < er; r++) begin
          q_rch.push_back(c); q_rstep.push_back(s);
          q_rdata.push_back(((s + 1) * sz + c * 2048) % 16384);
          q_rlast.push_back((c == NCH - 1 && s == es - 1 && r == er - 1) ? 1 : 0);
        end
      end
    end
    q_dsel.push_back(0); q_dword.push_back(0);
    cfg_num_steps = SW'(ns); cfg_repeats = RW'(nr); cfg_settle = TW'(st);
    cfg_step_size = DW'(sz); cfg_threshold = DW'(th);
    settle_cfg = st;
    ab_seen = 0;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, "R8 scan returns to idle", int'(busy), 0);
    chk(q_rch.size() == 0, "R4 all expected records delivered", q_rch.size(), 0);
    chk(q_dsel.size() == 0, "R8 final zero load issued", q_dsel.size(), 0);
  endtask

  task automatic pulse_abort();
    @(posedge clk); #1 abort = 1'b1;
    @(posedge clk); #1 abort = 1'b0;
  endtask

  initial begin
    int base;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !pulse_sw && !dac_load && !adc_start && !rec_valid,
        "R10 reset state", int'({busy, pulse_sw, dac_load, adc_start, rec_valid}), 0);

    // Scan A: three steps, two repeats, start pulse while busy (R1)
    base = n_acc;
    start_scan(3, 2, 3, 50, 777);
    while (n_acc < base + 5) @(negedge clk);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_idle();
    chk(n_acc - base == NCH * 3 * 2, "R4 record count with repeats", n_acc - base, NCH * 6);

    // Scan B: zero counts treated as one, no settle, backpressure (R4, R7)
    rdy_mode = 1;
    base = n_acc;
    start_scan(0, 0, 0, 100, 5);
    wait_idle();
    chk(n_acc - base == NCH, "R4 zero counts act as one", n_acc - base, NCH);

    // Scan C: thirty 50-unit steps up to 1500 (R2)
    base = n_acc;
    start_scan(30, 1, 1, 50, 1000);
    wait_idle();
    chk(n_acc - base == NCH * 30, "R2 full amplitude ramp", n_acc - base, NCH * 30);

    // Scan D: abort during a conversion (R9)
    base = n_conv;
    start_scan(2, 3, 2, 40, 9);
    while (n_conv < base + 3) @(negedge clk);
    base = n_acc;
    pulse_abort();
    wait_idle();
    repeat (40) @(negedge clk);
    chk(n_acc == base, "R9 no records after abort", n_acc - base, 0);

    // Scan E: abort while the threshold load is in flight (R9)
    rdy_mode = 0;
    base = n_acc;
    start_scan(2, 2, 1, 30, 321);
    pulse_abort();
    wait_idle();
    repeat (40) @(negedge clk);
    chk(n_acc == base, "R9 deferred zero load after abort", n_acc - base, 0);

    // Scan F: normal scan after abort
    base = n_acc;
    start_scan(2, 2, 5, 200, 64);
    wait_idle();
    chk(n_acc - base == NCH * 4, "R5 all channels after recovery", n_acc - base, NCH * 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule